// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside the ECC decoder of a DRAM controller. It turns the decoder's single-cycle error pulses into state that software can read. There are two error classes, correctable and uncorrectable. Each class has a saturating counter and a captured faulting address. The uncorrectable class keeps the address of its first error since the last clear. The correctable class keeps the address of its most recent error. An active-high, level-sensitive interrupt follows the counters through two enable bits.

Software reaches the block through a plain 32-bit register port with separate read and write strobes. A read strobe returns data on the next cycle. A write-protection key guards every register except the key register itself, so one stray write cannot change the configuration or clear the error log. A configuration register holds the ECC-on bit and the DRAM-type bit, and both also drive output pins for the rest of the controller. The error inputs are pulse events that cannot be refused, so they have no valid/ready handshake. The block takes one pulse per class per clock and never applies back-pressure.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the block is locked. Reading offsets 0x00, 0x04, 0x50, 0x58 and 0x5C returns 0, `irq` is 0 and both configuration pins are 0.
- R2: Writing exactly 0xFC600309 to offset 0x00 unlocks the block, and writing any other value there locks it. Reading offset 0x00 returns the lock state in bit 0, where 1 means unlocked.
- R3: While the block is locked, writes to offsets 0x04 and 0x50 change nothing.
- R4: In the configuration register at 0x04, bit 7 is ECC-on and drives `ecc_on`. Bit 4 is the DRAM type (1 = DDR4, 0 = DDR3) and drives `dram_ddr4`. All other bits read as 0.
- R5: While ECC-on is 0, error pulses leave the counts and the captured addresses unchanged.
- R6: Each accepted correctable pulse adds one to the count in bits 23:16 of offset 0x50. Each accepted uncorrectable pulse adds one to the count in bits 15:12. Pulses of both classes in the same cycle are both counted.
- R7: The correctable count stops at 255 and the uncorrectable count stops at 15. Neither wraps.
- R8: Offset 0x58 holds the address of the first uncorrectable error since reset or the last clear. Later uncorrectable errors do not change it.
- R9: Offset 0x5C holds the address of the latest correctable error. Each accepted correctable pulse overwrites it.
- R10: Bit 31 of 0x50 is a clear control and reads back as written. From one cycle after it becomes 1 until software writes it back to 0, both counts and both addresses stay 0 and pulses are not counted.
- R11: `irq` is high exactly when (bit 0 of 0x50 is 1 and the correctable count is nonzero) or (bit 1 is 1 and the uncorrectable count is nonzero).
- R12: A read strobe places the addressed register on `bus_rdata` in the next cycle, whatever the lock state. Undefined offsets read 0. Writes to the count fields and to 0x58 and 0x5C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_ofs | input | OFS_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ce_pulse | input | 1 | Correctable-error event, one cycle per error |
| ce_addr | input | ERR_ADDR_W | Faulting address for `ce_pulse` |
| ue_pulse | input | 1 | Uncorrectable-error event, one cycle per error |
| ue_addr | input | ERR_ADDR_W | Faulting address for `ue_pulse` |
| ecc_on | output | 1 | ECC-on configuration bit |
| dram_ddr4 | output | 1 | DRAM-type configuration bit, 1 = DDR4 |
| irq | output | 1 | Level-high error interrupt |

## Verification
The hardest state to reach from the ports is a saturated counter, because the correctable count needs 255 separate accepted pulses before its limit shows. The bench drives an unbroken run of 260 addressed pulses and reads the count and the latest address after every one, so it covers every count value, the exact point where the count stops, and the overwrite rule at each step. A second run of 20 uncorrectable pulses does the same for the 4-bit count and the first-address rule. The interrupt is swept over all enable pairs against every empty or non-empty combination of the two counters.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int          WORD_W     = 32;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  // byte offsets of the register set
  localparam int OFS_KEY   = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_CTL   = 'h50;
  localparam int OFS_UEADR = 'h58;
  localparam int OFS_CEADR = 'h5C;

  // field positions decoded by software
  localparam int CFG_ECC_BIT  = 7;
  localparam int CFG_DDR4_BIT = 4;
  localparam int CTL_CLR_BIT  = 31;
  localparam int CTL_CE_LSB   = 16;
  localparam int CTL_UE_LSB   = 12;
  localparam int CTL_IEN_W    = 2;
endpackage

// File: rtl/ecc_key_guard.sv
module ecc_key_guard #(
  parameter int           W   = 32,
  parameter logic [W-1:0] KEY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_wr,
  input  logic [W-1:0] key_data,
  output logic         open
);
  always_ff @(posedge clk) begin
    if (!rst_n)      open <= 1'b0;
    else if (key_wr) open <= (key_data == KEY);
  end

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == KEY) |=> open);
  // R2
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != KEY) |=> !open);
  // R2
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(open));
endmodule

// File: rtl/ecc_err_track.sv
module ecc_err_track #(
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 32,
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic capture;

  generate
    if (KEEP_FIRST) begin : g_first
      assign capture = (cnt == '0);
    end else begin : g_latest
      assign capture = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt  <= '0;
      addr <= '0;
    end else if (hit) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (capture)        addr <= hit_addr;
    end
  end

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && addr == '0));
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  generate
    if (KEEP_FIRST) begin : g_first_chk
      // R8
      first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != '0) |=> $stable(addr));
    end else begin : g_latest_chk
      // R9
      last_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> addr == $past(hit_addr));
    end
  endgenerate
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int OFS_W      = 8,
  parameter int CE_CNT_W   = 8,
  parameter int UE_CNT_W   = 4,
  parameter int ERR_ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [OFS_W-1:0]      bus_ofs,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  ce_pulse,
  input  logic [ERR_ADDR_W-1:0] ce_addr,
  input  logic                  ue_pulse,
  input  logic [ERR_ADDR_W-1:0] ue_addr,
  output logic                  ecc_on,
  output logic                  dram_ddr4,
  output logic                  irq
);
  localparam logic [OFS_W-1:0] A_KEY = OFS_W'(OFS_KEY);
  localparam logic [OFS_W-1:0] A_CFG = OFS_W'(OFS_CFG);
  localparam logic [OFS_W-1:0] A_CTL = OFS_W'(OFS_CTL);
  localparam logic [OFS_W-1:0] A_UEA = OFS_W'(OFS_UEADR);
  localparam logic [OFS_W-1:0] A_CEA = OFS_W'(OFS_CEADR);

  logic                  unlocked;
  logic                  wr_ok;
  logic                  clr_bit;
  logic [CTL_IEN_W-1:0]  ien;
  logic [CE_CNT_W-1:0]   ce_cnt;
  logic [UE_CNT_W-1:0]   ue_cnt;
  logic [ERR_ADDR_W-1:0] ce_last;
  logic [ERR_ADDR_W-1:0] ue_first;
  logic [WORD_W-1:0]     rd_val;

  ecc_key_guard #(.W(WORD_W), .KEY(UNLOCK_KEY)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (bus_wr && bus_ofs == A_KEY),
    .key_data (bus_wdata),
    .open     (unlocked)
  );

  assign wr_ok = bus_wr && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_on    <= 1'b0;
      dram_ddr4 <= 1'b0;
      clr_bit   <= 1'b0;
      ien       <= '0;
    end else if (wr_ok) begin
      if (bus_ofs == A_CFG) begin
        ecc_on    <= bus_wdata[CFG_ECC_BIT];
        dram_ddr4 <= bus_wdata[CFG_DDR4_BIT];
      end
      if (bus_ofs == A_CTL) begin
        clr_bit <= bus_wdata[CTL_CLR_BIT];
        ien     <= bus_wdata[CTL_IEN_W-1:0];
      end
    end
  end

  ecc_err_track #(.CNT_W(CE_CNT_W), .ADDR_W(ERR_ADDR_W), .KEEP_FIRST(1'b0)) u_ce (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_bit),
    .hit      (ce_pulse && ecc_on),
    .hit_addr (ce_addr),
    .cnt      (ce_cnt),
    .addr     (ce_last)
  );

  ecc_err_track #(.CNT_W(UE_CNT_W), .ADDR_W(ERR_ADDR_W), .KEEP_FIRST(1'b1)) u_ue (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_bit),
    .hit      (ue_pulse && ecc_on),
    .hit_addr (ue_addr),
    .cnt      (ue_cnt),
    .addr     (ue_first)
  );

  always_comb begin
    rd_val = '0;
    case (bus_ofs)
      A_KEY: rd_val[0] = unlocked;
      A_CFG: begin
        rd_val[CFG_ECC_BIT]  = ecc_on;
        rd_val[CFG_DDR4_BIT] = dram_ddr4;
      end
      A_CTL: begin
        rd_val[CTL_CLR_BIT]               = clr_bit;
        rd_val[CTL_CE_LSB +: CE_CNT_W]    = ce_cnt;
        rd_val[CTL_UE_LSB +: UE_CNT_W]    = ue_cnt;
        rd_val[CTL_IEN_W-1:0]             = ien;
      end
      A_UEA: rd_val = WORD_W'(ue_first);
      A_CEA: rd_val = WORD_W'(ce_last);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign irq = (ien[0] && ce_cnt != '0) || (ien[1] && ue_cnt != '0);

  // R3
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked) |=> $stable({ecc_on, dram_ddr4, clr_bit, ien}));
  // R5
  off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_on && !clr_bit) |=> $stable({ce_cnt, ue_cnt, ce_last, ue_first}));
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_cnt == '0 && ue_cnt == '0) |-> !irq);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_ofs = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ce_pulse = 1'b0;
  logic [31:0] ce_addr = '0;
  logic        ue_pulse = 1'b0;
  logic [31:0] ue_addr = '0;
  logic        ecc_on, dram_ddr4, irq;

  int checks = 0;
  int errors = 0;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  always #2 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_pulse(ce_pulse), .ce_addr(ce_addr),
    .ue_pulse(ue_pulse), .ue_addr(ue_addr), .ecc_on(ecc_on), .dram_ddr4(dram_ddr4), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_ofs = ofs;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] ofs, input logic [31:0] exp);
    logic [31:0] d;
    rd(ofs, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input logic c, input logic [31:0] ca, input logic u, input logic [31:0] ua);
    @(negedge clk);
    ce_pulse = c; ce_addr = ca; ue_pulse = u; ue_addr = ua;
    @(negedge clk);
    ce_pulse = 1'b0; ue_pulse = 1'b0;
  endtask

  task automatic clear_log();
    wr(8'h50, 32'h8000_0000);
    @(negedge clk);
    wr(8'h50, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk("R1 key", 8'h00, 0);
    rdchk("R1 cfg", 8'h04, 0);
    rdchk("R1 ctl", 8'h50, 0);
    rdchk("R1 ueaddr", 8'h58, 0);
    rdchk("R1 ceaddr", 8'h5C, 0);
    chk("R1 pins", {29'b0, irq, ecc_on, dram_ddr4}, 0);

    // R3 locked writes ignored
    wr(8'h04, 32'h90);
    wr(8'h50, 32'h8000_0003);
    rdchk("R3 cfg locked", 8'h04, 0);
    rdchk("R3 ctl locked", 8'h50, 0);

    // R2 key handling
    wr(8'h00, 32'h1234_5678);
    rdchk("R2 wrong key", 8'h00, 0);
    wr(8'h00, KEY);
    rdchk("R2 unlock", 8'h00, 1);

    // R4 configuration sweep
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'(i) * 32'h2493_6D25;
      wr(8'h04, v);
      rdchk("R4 cfg read", 8'h04, v & 32'h90);
      chk("R4 cfg pins", {30'b0, ecc_on, dram_ddr4}, {30'b0, v[7], v[4]});
    end

    // R5 ECC off: pulses ignored
    wr(8'h04, 32'h10);
    for (int i = 0; i < 3; i++) pulse(1'b1, 32'hDEAD_0000 + 32'(i), 1'b1, 32'hBEEF_0000);
    rdchk("R5 counts", 8'h50, 0);
    rdchk("R5 ceaddr", 8'h5C, 0);
    rdchk("R5 ueaddr", 8'h58, 0);

    // R6 R7 R9 correctable sweep past saturation
    wr(8'h04, 32'h80);
    for (int n = 1; n <= 260; n++) begin
      int e;
      e = (n > 255) ? 255 : n;
      pulse(1'b1, 32'h1000_0000 + 32'(n) * 4, 1'b0, 0);
      rdchk("R6 R7 ce count", 8'h50, 32'(e) << 16);
      rdchk("R9 ce latest", 8'h5C, 32'h1000_0000 + 32'(n) * 4);
    end

    // R10 clear holds everything at zero
    wr(8'h50, 32'h8000_0000);
    @(negedge clk);
    rdchk("R10 cleared", 8'h50, 32'h8000_0000);
    pulse(1'b1, 32'h5555_0000, 1'b1, 32'h6666_0000);
    rdchk("R10 held", 8'h50, 32'h8000_0000);
    rdchk("R10 ceaddr", 8'h5C, 0);
    rdchk("R10 ueaddr", 8'h58, 0);
    wr(8'h50, 32'h0);
    rdchk("R10 released", 8'h50, 0);

    // R6 R7 R8 uncorrectable sweep past saturation
    for (int n = 1; n <= 20; n++) begin
      int e;
      e = (n > 15) ? 15 : n;
      pulse(1'b0, 0, 1'b1, 32'h2000_0000 + 32'(n) * 8);
      rdchk("R6 R7 ue count", 8'h50, 32'(e) << 12);
      rdchk("R8 ue first", 8'h58, 32'h2000_0008);
    end

    // R6 simultaneous classes
    clear_log();
    pulse(1'b1, 32'hA0, 1'b1, 32'hB0);
    rdchk("R6 both", 8'h50, 32'h0001_1000);

    // R11 interrupt sweep
    for (int e = 0; e < 4; e++)
      for (int c = 0; c < 2; c++)
        for (int u = 0; u < 2; u++) begin
          clear_log();
          if (c != 0 || u != 0) pulse(c[0], 32'h40, u[0], 32'h80);
          wr(8'h50, 32'(e));
          chk("R11 irq", {31'b0, irq}, {31'b0, (e[0] && c != 0) || (e[1] && u != 0)});
        end

    // R12 read-only fields, undefined offsets, reads while locked
    clear_log();
    pulse(1'b1, 32'h77, 1'b1, 32'h99);
    wr(8'h50, 32'h00FF_F000);
    rdchk("R12 ro counts", 8'h50, 32'h0001_1000);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    rdchk("R12 ro ueaddr", 8'h58, 32'h99);
    rdchk("R12 ro ceaddr", 8'h5C, 32'h77);
    rdchk("R12 undef 08", 8'h08, 0);
    rdchk("R12 undef 54", 8'h54, 0);
    rdchk("R12 undef FC", 8'hFC, 0);
    wr(8'h00, ~KEY);
    rdchk("R2 relock", 8'h00, 0);
    wr(8'h04, 32'h0);
    rdchk("R3 relocked cfg", 8'h04, 32'h80);
    rdchk("R12 locked read", 8'h50, 32'h0001_1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule